// File: doc/BRIEF.md
# Register-Controlled Serial Management Master

This block lets software reach the management registers of an Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data). It has four 32-bit registers behind a small select/write port. Software loads the target PHY address, the PHY register number and the direction. For a write it also loads a 16-bit data word. It then sets the start bit in the control register, with the enable bit set in the same write.

The block then clocks out one IEEE 802.3 clause-22 frame of 64 bits, MSB first. The frame is 32 preamble ones, start `01`, opcode `10` (read) or `01` (write), 5 PHY address bits, 5 register bits, a two-bit turnaround and 16 data bits. MDC is produced from the system clock by a build-time divider, so its frequency never exceeds the configured maximum.

The start bit doubles as the busy flag. It reads 1 for the whole frame and clears itself when the last MDC cycle ends. At that point a read has already placed the PHY's 16 bits in the read-data register.

Top module: `mdio_reg_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register select 1 (address) reads back bits 10:0 as written, with bits 4:0 holding the PHY register number, bits 9:5 the PHY address and bit 10 the direction (1 read, 0 write). Register select 2 (write data) reads back bits 15:0. All other bits read 0.
- R3: Control bit 3 (enable) reads back as last written. Register select 0 is control.
- R4: A control write with bit 0 and bit 3 both set, while idle, starts a frame. Control bit 0 then reads 1 until the frame ends and reads 0 afterwards.
- R5: A control write with bit 0 set and bit 3 clear starts nothing: status stays 0 and MDC stays low.
- R6: A start request made while a frame is running is ignored. The running frame continues unchanged, even if the address register is rewritten.
- R7: A write frame carries 32 ones, `01`, `01`, PHY address, register number, `10` and the data, MSB first. MDIO is driven for all 64 bits and changes only while MDC is low.
- R8: A read frame carries opcode `10`. MDIO is released from bit 46 (the turnaround) to the end. The 16 bits the PHY presents at the last 16 MDC rising edges land, first bit as MSB, in register select 3 (read data) by the time status reads 0.
- R9: MDC stays low while idle. While busy, each MDC half period lasts HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)) system clocks, and a frame spans 64 MDC cycles.
- R10: Writes to the read-data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 control, 1 address, 2 write data, 3 read data |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected register value, registered (one cycle after select) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_in | input | 1 | MDIO value seen on the pad |

## Verification
The bench goes after the start gating. A design that ignored the enable bit would clock a frame after a start with enable clear. One that honoured a second start mid-frame would restart the shift register, and the frame seen on the wire would no longer match the queued one. The turnaround is checked bit by bit against the output enable: a master that kept driving through bit 46 or 47 would fight the PHY. Read data is checked with asymmetric patterns, so a design that sampled one MDC edge late or early, or shifted LSB first, would return a shifted or reversed word. Each half period is measured, so a miscounting divider shows up as a wrong MDC rate.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_WDATA = 2'd2,
    SEL_RDATA = 2'd3
  } reg_sel_e;

  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int DATA_W    = 16;
  localparam int FLD_W     = 5;

  localparam int CTRL_GO_BIT = 0;
  localparam int CTRL_EN_BIT = 3;
  localparam int ADDR_OP_BIT = 10;

  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic is_read, input logic [FLD_W-1:0] phy,
      input logic [FLD_W-1:0] regn, input logic [DATA_W-1:0] data);
    logic [1:0] op;
    logic [1:0] ta;
    op = is_read ? 2'b10 : 2'b01;
    ta = is_read ? 2'b11 : 2'b10;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regn, ta,
            (is_read ? {DATA_W{1'b1}} : data)};
  endfunction

  function automatic int half_cycles(input longint clk_hz, input longint mdc_hz);
    longint h;
    h = (clk_hz + 2 * mdc_hz - 1) / (2 * mdc_hz);
    if (h < 1) h = 1;
    return int'(h);
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = run && (cnt == CW'(HALF - 1));
  assign rise_ev = wrap && !mdc;
  assign fall_ev = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_idle_mdc_low_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !mdc) |=> !mdc);

endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              is_read_i,
  input  logic [FLD_W-1:0]  phy_i,
  input  logic [FLD_W-1:0]  regn_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_in,
  output logic              busy,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [IW-1:0]        bit_idx;
  logic                 is_read;
  logic [DATA_W-1:0]    rx_sh;
  logic [IW:0]          nxt_idx;
  logic                 last_bit;

  assign nxt_idx  = {1'b0, bit_idx} + 1'b1;
  assign last_bit = (bit_idx == IW'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      is_read  <= 1'b0;
      mdio_out <= 1'b1;
      mdio_oe  <= 1'b0;
    end else if (!busy) begin
      if (start_req) begin
        busy     <= 1'b1;
        shreg    <= build_frame(is_read_i, phy_i, regn_i, wdata_i);
        bit_idx  <= '0;
        is_read  <= is_read_i;
        mdio_out <= 1'b1;
        mdio_oe  <= 1'b1;
      end
    end else if (fall_ev) begin
      if (last_bit) begin
        busy     <= 1'b0;
        mdio_out <= 1'b1;
        mdio_oe  <= 1'b0;
      end else begin
        bit_idx  <= nxt_idx[IW-1:0];
        shreg    <= {shreg[FRAME_LEN-2:0], 1'b0};
        mdio_out <= shreg[FRAME_LEN-2];
        mdio_oe  <= !(is_read && (nxt_idx >= (IW+1)'(TA_POS)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh   <= '0;
      rd_data <= '0;
    end else begin
      if (busy && is_read && rise_ev && (bit_idx >= IW'(DATA_POS)))
        rx_sh <= {rx_sh[DATA_W-2:0], mdio_in};
      if (busy && is_read && fall_ev && last_bit)
        rd_data <= rx_sh;
    end
  end

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req && !fall_ev) |=> (busy && bit_idx == $past(bit_idx)));

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  assert_ta_release_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && bit_idx >= IW'(TA_POS)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              start_req,
  output logic              is_read_o,
  output logic [FLD_W-1:0]  phy_o,
  output logic [FLD_W-1:0]  regn_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int AW = ADDR_OP_BIT + 1;

  logic [AW-1:0] addr_q;
  logic          en_q;
  logic          ctrl_wr;

  assign ctrl_wr   = bus_we && (bus_sel == SEL_CTRL);
  assign start_req = ctrl_wr && bus_wdata[CTRL_GO_BIT] && bus_wdata[CTRL_EN_BIT];

  assign regn_o    = addr_q[FLD_W-1:0];
  assign phy_o     = addr_q[2*FLD_W-1:FLD_W];
  assign is_read_o = addr_q[ADDR_OP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_o <= '0;
      en_q    <= 1'b0;
    end else if (bus_we) begin
      case (reg_sel_e'(bus_sel))
        SEL_CTRL:  en_q    <= bus_wdata[CTRL_EN_BIT];
        SEL_ADDR:  addr_q  <= bus_wdata[AW-1:0];
        SEL_WDATA: wdata_o <= bus_wdata[DATA_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (reg_sel_e'(bus_sel))
        SEL_CTRL: begin
          bus_rdata[CTRL_GO_BIT] <= busy_i;
          bus_rdata[CTRL_EN_BIT] <= en_q;
        end
        SEL_ADDR:  bus_rdata[AW-1:0]     <= addr_q;
        SEL_WDATA: bus_rdata[DATA_W-1:0] <= wdata_o;
        default:   bus_rdata[DATA_W-1:0] <= rd_data_i;
      endcase
    end
  end

  assert_en_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[CTRL_GO_BIT] && !bus_wdata[CTRL_EN_BIT] && !busy_i)
      |=> !busy_i);

endmodule

// File: rtl/mdio_reg_master.sv
module mdio_reg_master
  import mdio_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint MDC_MAX_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int HALF = half_cycles(CLK_HZ, MDC_MAX_HZ);

  logic              start_req, is_read, busy, rise_ev, fall_ev;
  logic [FLD_W-1:0]  phy, regn;
  logic [DATA_W-1:0] wdata, rd_data;

  mdio_csr u_csr (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy),
    .rd_data_i(rd_data), .start_req(start_req), .is_read_o(is_read),
    .phy_o(phy), .regn_o(regn), .wdata_o(wdata)
  );

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy), .mdc(mdc),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_shift_engine u_eng (
    .clk(clk), .rst(rst), .start_req(start_req), .is_read_i(is_read),
    .phy_i(phy), .regn_i(regn), .wdata_i(wdata), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .mdio_in(mdio_in), .busy(busy),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  assert_mdio_stable_high_R7: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_out));

  assert_busy_runs_mdc_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> busy);

endmodule

// File: tb/mdio_reg_master_test.sv
module mdio_reg_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;

  logic        clk = 0, rst = 1;
  logic [1:0]  bus_sel = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1;

  int n_checks = 0, n_fail = 0;

  logic [63:0] exp_bits[$];
  logic [63:0] exp_oe[$];
  logic [15:0] phy_word = 0;

  mdio_reg_master uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: capture MDIO at each MDC rising edge, compare whole frames
  logic        mdc_d = 0;
  int          cap_idx = 0, hp_cnt = 0, hp_bad = 0;
  logic [63:0] got_o, got_oe;
  always @(negedge clk) begin
    hp_cnt++;
    if (mdc && !mdc_d) begin
      if (cap_idx > 0 && hp_cnt != HALF) hp_bad++;
      hp_cnt = 0;
      got_o[63-cap_idx]  = mdio_out;
      got_oe[63-cap_idx] = mdio_oe;
      cap_idx++;
      if (cap_idx == 64) begin
        logic [63:0] eb, eo;
        cap_idx = 0;
        if (exp_bits.size() == 0) begin
          check(0, "R6 unexpected frame", got_o, 0);
        end else begin
          eb = exp_bits.pop_front();
          eo = exp_oe.pop_front();
          check(got_oe == eo, "R7/R8 output enable pattern", got_oe, eo);
          check(((got_o ^ eb) & eo) == 0, "R7/R8 frame bits", got_o, eb);
        end
        check(hp_bad == 0, "R9 half periods", hp_bad, 0);
        hp_bad = 0;
      end
    end else if (!mdc && mdc_d) begin
      if (hp_cnt != HALF) hp_bad++;
      hp_cnt = 0;
      // PHY model: present next bit for index cap_idx
      if (cap_idx >= 48) mdio_in = phy_word[15-(cap_idx-48)];
      else if (cap_idx == 47) mdio_in = 1'b0;
      else mdio_in = 1'b1;
    end
    mdc_d = mdc;
  end

  task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); bus_sel = s; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); bus_sel = s; bus_we = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [31:0] v;
    cycles = 0;
    for (int i = 0; i < 10000; i++) begin
      bus_read(2'd0, v);
      cycles += 2;
      if (!v[0]) return;
    end
    check(0, "R4 status never cleared", 1, 0);
  endtask

  task automatic run_frame(input bit rd, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] v;
    int          cyc;
    exp_bits.push_back({32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                        (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)});
    exp_oe.push_back(rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}});
    phy_word = d;
    bus_write(2'd1, {21'h0, rd, phy, rg});
    if (!rd) bus_write(2'd2, {16'h0, d});
    bus_write(2'd0, 32'h9);
    bus_read(2'd0, v);
    check(v == 32'h9, "R4 status set during frame", v, 32'h9);
    wait_idle(cyc);
    bus_read(2'd0, v);
    check(v == 32'h8, "R4 status cleared after frame", v, 32'h8);
    if (rd) begin
      bus_read(2'd3, v);
      check(v == {16'h0, d}, "R8 read data", v, {16'h0, d});
    end
  endtask

  initial begin
    logic [31:0] v;
    int cyc;
    bit mdc_seen;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      bus_read(s[1:0], v);
      check(v == 0, "R1 reset register value", v, 0);
    end
    check(!mdc && !mdio_oe, "R1 mdc/oe low after reset", {mdc, mdio_oe}, 0);
    // R2 field readback
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, v);
    check(v == 32'h7FF, "R2 address readback", v, 32'h7FF);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, v);
    check(v == 32'hFFFF, "R2 write-data readback", v, 32'hFFFF);
    // R10 read-data not writable
    bus_write(2'd3, 32'h1234);
    bus_read(2'd3, v);
    check(v == 0, "R10 read data unchanged by write", v, 0);
    // R3 enable readback
    bus_write(2'd0, 32'h8);
    bus_read(2'd0, v);
    check(v == 32'h8, "R3 enable set readback", v, 32'h8);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, v);
    check(v == 32'h0, "R3 enable clear readback", v, 0);
    // R5 start without enable
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, v);
    check(v == 0, "R5 status after start without enable", v, 0);
    mdc_seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mdc) mdc_seen = 1;
    end
    check(!mdc_seen, "R5 mdc idle after gated start", mdc_seen, 0);
    // R7 write frames
    run_frame(0, 5'h1F, 5'h00, 16'hA5C3);
    run_frame(0, 5'h03, 5'h1E, 16'h0001);
    // R8 read frames
    run_frame(1, 5'h07, 5'h01, 16'h8001);
    run_frame(1, 5'h10, 5'h0B, 16'h3C96);
    // R6 start during frame ignored
    exp_bits.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'hBEEF});
    exp_oe.push_back({64{1'b1}});
    bus_write(2'd1, {21'h0, 1'b0, 5'h0A, 5'h15});
    bus_write(2'd2, 32'hBEEF);
    bus_write(2'd0, 32'h9);
    repeat (300) @(negedge clk);
    bus_write(2'd1, {21'h0, 1'b1, 5'h01, 5'h02});
    bus_write(2'd0, 32'h9);
    bus_read(2'd0, v);
    check(v == 32'h9, "R6 status still set after second start", v, 32'h9);
    wait_idle(cyc);
    cyc += 308;
    check(cyc >= 128*HALF && cyc <= 128*HALF + 12, "R6/R9 single frame length",
          cyc, 128*HALF);
    repeat (50) @(negedge clk);
    check(exp_bits.size() == 0, "R6 every queued frame observed",
          exp_bits.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule